// File: doc/BRIEF.md
# Flash Erase-Verify Sequencer

This block runs on the host side of a byte-wide flash part and carries out a full erase followed by a blank check. A single start pulse loads an inclusive address window. The block then drives a sequence of bus cycles into the flash command port. Each cycle is handed over on a valid/acknowledge handshake. First comes an erase, made of two command writes. Then the block waits a fixed settling time. After that it checks each location in the window in ascending order. For every location it writes a verify command that carries the address, then reads back the result.

A location is blank only when the read returns all ones. If any other value comes back, the block erases the part again and starts checking from the failing location. It does not go back to the start of the window. A parameter caps how many extra erases are allowed. When the check ends, for either reason, the block writes a program-setup command so that the part leaves verify mode. It then reports either done or error.

Top module: `flash_erase_verify`

## Requirements
- R1: After reset, busy, done and error are low and no bus cycle is requested (bus_valid low).
- R2: A requested bus cycle keeps bus_valid high and bus_we, bus_addr and bus_wdata unchanged until the clock edge at which bus_ack is seen high. Only one cycle is outstanding at a time.
- R3: An erase consists of two consecutive write cycles carrying data 20h. The address does not matter. The block writes no data values other than 20h, A0h and 40h.
- R4: After the second erase write completes, bus_valid stays low for exactly SETTLE_CYCLES+2 clock cycles. The next request is the verify command.
- R5: Each location is checked with a write of A0h at that location's address, followed by one read cycle. Checked addresses run upward from first_addr and never exceed last_addr.
- R6: A location passes only when the verify read returns exactly FFh. Any other value, including one that differs in a single bit, triggers a new erase.
- R7: After a re-erase, checking resumes at the location that failed. It never moves back below that location.
- R8: At most MAX_RETRY re-erases are issued in one run. A failed read once that limit has been used up ends the run with error.
- R9: Every run ends with exactly one write of 40h, and this is the last bus cycle. At that point done goes high if every location passed, or error goes high if the limit was hit. The flag stays high until the next accepted start.
- R10: busy is high from the cycle after an accepted start until the final write completes, and done and error are low while busy. A start pulse while busy changes nothing, including the address window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run (accepted only when idle) |
| first_addr | input | AW | Lowest address to check |
| last_addr | input | AW | Highest address to check |
| bus_valid | output | 1 | Bus cycle requested |
| bus_we | output | 1 | 1 = write cycle, 0 = read cycle |
| bus_addr | output | AW | Bus cycle address |
| bus_wdata | output | 8 | Write data |
| bus_ack | input | 1 | Device completes the current cycle |
| bus_rdata | input | 8 | Read data, valid with bus_ack |
| busy | output | 1 | Run in progress |
| done | output | 1 | Last run finished with every location blank |
| error | output | 1 | Last run hit the re-erase limit |

## Verification
busy goes high, and any old done or error flag clears, one clock edge after start is sampled high. A request appears on the bus one cycle after the previous one completes. The exception is the verify command after an erase, which appears SETTLE_CYCLES+2 cycles later; the bench's flash model counts the idle samples in that gap. The acknowledge latency is set per vector from zero to three cycles. The model answers a verify read from its own count of erases. done or error shows on the edge that completes the 40h write. The bench samples all outputs on falling edges, after the flags have settled, and compares them with counts taken by the model at the bus.

// File: rtl/fev_pkg.sv
package fev_pkg;
    localparam logic [7:0] CMD_ERASE  = 8'h20;
    localparam logic [7:0] CMD_VERIFY = 8'hA0;
    localparam logic [7:0] CMD_EXIT   = 8'h40;
    localparam logic [7:0] BLANK_BYTE = 8'hFF;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ERASE_A,
        ST_ERASE_B,
        ST_SETTLE,
        ST_VCMD,
        ST_VREAD,
        ST_EXIT
    } seq_state_t;
endpackage

// File: rtl/fev_bus_port.sv
module fev_bus_port #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          issue,
    input  logic          iss_we,
    input  logic [AW-1:0] iss_addr,
    input  logic [7:0]    iss_wdata,
    input  logic          bus_ack,
    output logic          bus_valid,
    output logic          bus_we,
    output logic [AW-1:0] bus_addr,
    output logic [7:0]    bus_wdata,
    output logic          xfer_done,
    output logic          port_idle
);
    typedef struct packed {
        logic          valid;
        logic          we;
        logic [AW-1:0] addr;
        logic [7:0]    wdata;
    } port_t;

    port_t port_d, port_q;

    always_comb begin
        port_d = port_q;
        if (port_q.valid) begin
            if (bus_ack) begin
                port_d.valid = 1'b0;
            end
        end else if (issue) begin
            port_d.valid = 1'b1;
            port_d.we    = iss_we;
            port_d.addr  = iss_addr;
            port_d.wdata = iss_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            port_q <= '0;
        end else begin
            port_q <= port_d;
        end
    end

    assign bus_valid = port_q.valid;
    assign bus_we    = port_q.we;
    assign bus_addr  = port_q.addr;
    assign bus_wdata = port_q.wdata;
    assign xfer_done = port_q.valid & bus_ack;
    assign port_idle = ~port_q.valid;
endmodule

// File: rtl/fev_timer.sv
module fev_timer #(
    parameter int CYCLES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic expired
);
    localparam int CW = (CYCLES > 0) ? $clog2(CYCLES + 1) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = CW'(CYCLES);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/flash_erase_verify.sv
module flash_erase_verify
    import fev_pkg::*;
#(
    parameter int AW            = 16,
    parameter int SETTLE_CYCLES = 3,
    parameter int MAX_RETRY     = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] first_addr,
    input  logic [AW-1:0] last_addr,
    output logic          bus_valid,
    output logic          bus_we,
    output logic [AW-1:0] bus_addr,
    output logic [7:0]    bus_wdata,
    input  logic          bus_ack,
    input  logic [7:0]    bus_rdata,
    output logic          busy,
    output logic          done,
    output logic          error
);
    localparam int RW = (MAX_RETRY > 0) ? $clog2(MAX_RETRY + 1) : 1;

    typedef struct packed {
        seq_state_t    st;
        logic [AW-1:0] addr;
        logic [AW-1:0] last;
        logic [RW-1:0] tries;
        logic          fail;
        logic          done;
        logic          error;
    } seq_t;

    seq_t seq_d, seq_q;

    logic          issue;
    logic          iss_we;
    logic [7:0]    iss_wdata;
    logic          xfer_done;
    logic          port_idle;
    logic          settle_load;
    logic          settle_expired;
    logic [AW-1:0] last_lim;

    fev_bus_port #(.AW(AW)) u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .issue     (issue),
        .iss_we    (iss_we),
        .iss_addr  (seq_q.addr),
        .iss_wdata (iss_wdata),
        .bus_ack   (bus_ack),
        .bus_valid (bus_valid),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .xfer_done (xfer_done),
        .port_idle (port_idle)
    );

    fev_timer #(.CYCLES(SETTLE_CYCLES)) u_settle (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (settle_load),
        .expired (settle_expired)
    );

    always_comb begin
        seq_d       = seq_q;
        issue       = 1'b0;
        iss_we      = 1'b0;
        iss_wdata   = 8'h00;
        settle_load = 1'b0;
        unique case (seq_q.st)
            ST_IDLE: begin
                if (start) begin
                    seq_d.st    = ST_ERASE_A;
                    seq_d.addr  = first_addr;
                    seq_d.last  = last_addr;
                    seq_d.tries = '0;
                    seq_d.fail  = 1'b0;
                    seq_d.done  = 1'b0;
                    seq_d.error = 1'b0;
                end
            end
            ST_ERASE_A: begin
                issue     = port_idle;
                iss_we    = 1'b1;
                iss_wdata = CMD_ERASE;
                if (xfer_done) begin
                    seq_d.st = ST_ERASE_B;
                end
            end
            ST_ERASE_B: begin
                issue     = port_idle;
                iss_we    = 1'b1;
                iss_wdata = CMD_ERASE;
                if (xfer_done) begin
                    seq_d.st    = ST_SETTLE;
                    settle_load = 1'b1;
                end
            end
            ST_SETTLE: begin
                if (settle_expired) begin
                    seq_d.st = ST_VCMD;
                end
            end
            ST_VCMD: begin
                issue     = port_idle;
                iss_we    = 1'b1;
                iss_wdata = CMD_VERIFY;
                if (xfer_done) begin
                    seq_d.st = ST_VREAD;
                end
            end
            ST_VREAD: begin
                issue  = port_idle;
                iss_we = 1'b0;
                if (xfer_done) begin
                    if (bus_rdata == BLANK_BYTE) begin
                        if (seq_q.addr == seq_q.last) begin
                            seq_d.st = ST_EXIT;
                        end else begin
                            seq_d.addr = seq_q.addr + 1'b1;
                            seq_d.st   = ST_VCMD;
                        end
                    end else if (seq_q.tries == RW'(MAX_RETRY)) begin
                        seq_d.fail = 1'b1;
                        seq_d.st   = ST_EXIT;
                    end else begin
                        seq_d.tries = seq_q.tries + 1'b1;
                        seq_d.st    = ST_ERASE_A;
                    end
                end
            end
            ST_EXIT: begin
                issue     = port_idle;
                iss_we    = 1'b1;
                iss_wdata = CMD_EXIT;
                if (xfer_done) begin
                    seq_d.st    = ST_IDLE;
                    seq_d.done  = ~seq_q.fail;
                    seq_d.error = seq_q.fail;
                end
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q    <= '0;
            seq_q.st <= ST_IDLE;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign busy     = (seq_q.st != ST_IDLE);
    assign done     = seq_q.done;
    assign error    = seq_q.error;
    assign last_lim = seq_q.last;
endmodule

// File: rtl/fev_checker.sv
module fev_checker #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_valid,
    input logic          bus_we,
    input logic [AW-1:0] bus_addr,
    input logic [7:0]    bus_wdata,
    input logic          bus_ack,
    input logic          busy,
    input logic          done,
    input logic          error,
    input logic [AW-1:0] last_lim
);
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && !bus_ack |=> bus_valid && $stable(bus_we) && $stable(bus_addr) && $stable(bus_wdata)); // R2

    AST_WRITE_CODES: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && bus_we |-> (bus_wdata == 8'h20 || bus_wdata == 8'hA0 || bus_wdata == 8'h40)); // R3

    AST_VERIFY_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && bus_we && bus_wdata == 8'hA0 |-> bus_addr <= last_lim); // R5

    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && error)); // R9

    AST_BUSY_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !done && !error); // R10

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !bus_valid); // R1
endmodule

bind flash_erase_verify fev_checker #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_ack   (bus_ack),
    .busy      (busy),
    .done      (done),
    .error     (error),
    .last_lim  (last_lim)
);

// File: tb/sim_flash_erase_verify.sv
`timescale 1ns/1ps
module sim_flash_erase_verify;
    localparam int AW = 4;
    localparam int P_SETTLE = 3;
    localparam int P_RETRY = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] first_addr = '0;
    logic [AW-1:0] last_addr = '0;
    logic          bus_valid, bus_we;
    logic [AW-1:0] bus_addr;
    logic [7:0]    bus_wdata;
    logic          bus_ack = 1'b0;
    logic [7:0]    bus_rdata = 8'h00;
    logic          busy, done, error;

    always #10 clk = ~clk;

    flash_erase_verify #(.AW(AW), .SETTLE_CYCLES(P_SETTLE), .MAX_RETRY(P_RETRY)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start),
        .first_addr(first_addr), .last_addr(last_addr),
        .bus_valid(bus_valid), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
        .busy(busy), .done(done), .error(error)
    );

    typedef struct packed {
        logic [3:0] first;
        logic [3:0] last;
        logic [3:0] bad;
        logic [3:0] need;
        logic [1:0] lat;
        logic [7:0] badval;
        logic [3:0] exp_erases;
        logic [5:0] exp_reads;
        logic       exp_err;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{4'd0, 4'd15, 4'd5,  4'd1, 2'd0, 8'h5A, 4'd1, 6'd16, 1'b0},
        '{4'd2, 4'd9,  4'd5,  4'd2, 2'd1, 8'h5A, 4'd2, 6'd9,  1'b0},
        '{4'd3, 4'd3,  4'd3,  4'd3, 2'd2, 8'hFE, 4'd3, 6'd3,  1'b0},
        '{4'd4, 4'd10, 4'd7,  4'd4, 2'd0, 8'h5A, 4'd3, 6'd6,  1'b1},
        '{4'd0, 4'd15, 4'd15, 4'd2, 2'd3, 8'h5A, 4'd2, 6'd17, 1'b0},
        '{4'd6, 4'd12, 4'd6,  4'd5, 2'd1, 8'h7F, 4'd3, 6'd3,  1'b1}
    };

    int tests = 0;
    int fails = 0;

    // flash model state and per-run counters
    int m_first, m_last, m_bad, m_need, m_lat;
    logic [7:0] m_badval;
    int wcnt, erases, reads, orphan, back, resume_bad, range_bad;
    int exit_cnt, post_exit, gap_seen, gap_bad, low_cnt, viol;
    bit pend20, vmode, just_erased, have_prev, settle_watch, held_f;
    int latched, prev_a0;
    logic [7:0] last_w;
    logic [AW+8:0] held_v;

    task automatic clear_model();
        erases = 0; reads = 0; orphan = 0; back = 0; resume_bad = 0;
        range_bad = 0; exit_cnt = 0; post_exit = 0; gap_seen = 0;
        gap_bad = 0; low_cnt = 0; viol = 0; pend20 = 0; vmode = 0;
        just_erased = 0; have_prev = 0; settle_watch = 0; held_f = 0;
        latched = 0; prev_a0 = 0; last_w = 8'h00; held_v = '0;
    endtask

    function automatic int need_of(int a);
        return (a == m_bad) ? m_need : 1;
    endfunction

    always @(posedge clk) begin
        if (rst_n) begin
            if (bus_valid && held_f && {bus_we, bus_addr, bus_wdata} != held_v) viol++;
            held_f = bus_valid && !bus_ack;
            held_v = {bus_we, bus_addr, bus_wdata};
            if (settle_watch) begin
                if (!bus_valid) low_cnt++;
                else if (low_cnt > 0) begin
                    gap_seen++;
                    if (low_cnt != P_SETTLE + 2) gap_bad++;
                    settle_watch = 0;
                end
            end
        end
        if (!rst_n) begin
            bus_ack <= 1'b0;
            wcnt = 0;
        end else if (bus_ack) begin
            bus_ack <= 1'b0;
            wcnt = 0;
        end else if (bus_valid) begin
            if (wcnt == m_lat) begin
                bus_ack <= 1'b1;
                if (exit_cnt > 0) post_exit++;
                if (bus_we) begin
                    last_w = bus_wdata;
                    if (bus_wdata == 8'h20) begin
                        if (pend20) begin
                            erases++; pend20 = 0; just_erased = 1;
                            settle_watch = 1; low_cnt = 0; vmode = 0;
                        end else pend20 = 1;
                    end else begin
                        pend20 = 0;
                        if (bus_wdata == 8'hA0) begin
                            vmode = 1; latched = int'(bus_addr);
                            if (have_prev && int'(bus_addr) < prev_a0) back++;
                            prev_a0 = int'(bus_addr); have_prev = 1;
                            if (just_erased && erases > 1 && int'(bus_addr) != m_bad) resume_bad++;
                            just_erased = 0;
                            if (int'(bus_addr) < m_first || int'(bus_addr) > m_last) range_bad++;
                        end else if (bus_wdata == 8'h40) begin
                            exit_cnt++; vmode = 0;
                        end
                    end
                end else begin
                    reads++;
                    if (!vmode) orphan++;
                    bus_rdata <= (erases >= need_of(latched)) ? 8'hFF : m_badval;
                    vmode = 0;
                end
            end else wcnt++;
        end
    end

    task automatic chk(bit ok, string req, string what, int act, int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic run_vec(vec_t v, bit poke);
        int guard;
        m_first = v.first; m_last = v.last; m_bad = v.bad; m_need = v.need;
        m_lat = v.lat; m_badval = v.badval;
        clear_model();
        @(negedge clk);
        first_addr = v.first; last_addr = v.last; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R10", "busy after start", busy, 1);
        chk(!done && !error, "R9", "flags cleared by start", {done, error}, 0);
        guard = 0;
        while (!(done || error) && guard < 5000) begin
            @(negedge clk);
            guard++;
            if (poke && guard == 20) begin
                first_addr = 4'd0; last_addr = 4'd15; start = 1'b1;
            end else start = 1'b0;
        end
        start = 1'b0;
        chk(busy == 1'b0, "R10", "busy low at end", busy, 0);
        chk(done == !v.exp_err, "R9", "done flag", done, int'(!v.exp_err));
        chk(error == v.exp_err, "R8", "error flag", error, int'(v.exp_err));
        chk(erases == int'(v.exp_erases), "R8", "erase count", erases, int'(v.exp_erases));
        chk(reads == int'(v.exp_reads), "R5", "verify reads", reads, int'(v.exp_reads));
        chk(orphan == 0 && range_bad == 0, "R5", "reads without command / out of range", orphan + range_bad, 0);
        chk(back == 0 && resume_bad == 0, "R7", "resume position errors", back + resume_bad, 0);
        chk(exit_cnt == 1 && last_w == 8'h40 && post_exit == 0, "R9", "exit command count", exit_cnt, 1);
        chk(gap_seen > 0 && gap_bad == 0, "R4", "settle gap mismatches", gap_bad, 0);
        chk(viol == 0, "R2", "fields changed while waiting", viol, 0);
        chk(pend20 == 0, "R3", "unpaired erase write", int'(pend20), 0);
        repeat (3) @(negedge clk);
        chk(done == !v.exp_err && error == v.exp_err && !bus_valid, "R9", "flags held when idle", {done, error}, {!v.exp_err, v.exp_err});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        tests++; fails++;
        $display("FAIL R10 watchdog expired: actual 1 expected 0");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        m_first = 0; m_last = 0; m_bad = 0; m_need = 1; m_lat = 0; m_badval = 8'h00;
        clear_model();
        repeat (3) @(negedge clk);
        chk(!busy && !done && !error && !bus_valid, "R1", "outputs in reset", {busy, done, error, bus_valid}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!busy && !done && !error && !bus_valid, "R1", "outputs after reset", {busy, done, error, bus_valid}, 0);

        for (int i = 0; i < 6; i++) begin
            run_vec(VECS[i], 1'b0);
        end

        // directed: start while busy must change nothing (R10)
        run_vec(VECS[1], 1'b1);
        // directed: one-bit-off read value at the last location, zero latency (R6)
        run_vec('{4'd8, 4'd9, 4'd9, 4'd2, 2'd0, 8'hEF, 4'd2, 6'd3, 1'b0}, 1'b0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule